// File: doc/BRIEF.md
# Transmit Endpoint Packet Buffer with Auto-Validation

This block holds one device-to-host packet for a single endpoint. A local processor fills it through a data port that takes either one byte or two bytes per write. A length register sets the packet size. Writing the maximum-packet-size setting preloads the length register, and software may then overwrite it with a smaller value for a short final packet. When the stored byte count reaches the length, the buffer marks itself valid in the same clock edge as the completing write. A manual validate strobe can also release a short packet early.

Once the buffer is valid, the next IN token starts a byte-wide drain over a simple valid/ready handshake. The buffer frees itself after the last byte is accepted. A token that finds no valid packet gets a one-cycle NAK pulse. A write that arrives while a packet is held is dropped and sets a sticky overflow flag.

The controller has three states:
- `ST_FILL` accepts writes.
- `ST_READY` holds a validated packet.
- `ST_SEND` drains the packet.

Its transitions are:
- `FILL_TO_READY`, taken on auto-validation or on the manual strobe.
- `READY_TO_SEND`, taken on an IN token.
- `SEND_TO_FILL`, taken when the final byte is accepted.

Top module: `tx_ep_buffer`

## Requirements
- R1: After reset, `len_q`, `byte_count` and `overflow` read 0, and `buf_valid`, `tx_valid` and `nak` are low.
- R2: `mps_wr` loads `len_q` from `mps_val`, and `len_wr` loads it from `len_val`. Any value above DEPTH (64) is stored as DEPTH. When both strobes come in one cycle, `len_wr` wins.
- R3: In `ST_FILL`, an 8-bit write (`dp_wide`=0) stores `dp_data[7:0]` and raises `byte_count` by one. A 16-bit write (`dp_wide`=1) stores `dp_data[7:0]` first and `dp_data[15:8]` at the next location, and raises `byte_count` by two.
- R4: With `len_q` nonzero, the write that brings `byte_count` to `len_q` also validates the buffer, so `buf_valid` is high in the next cycle. A 16-bit write with room for only one byte stores the low byte alone.
- R5: With `len_q` = 0 there is no auto-validation, and writes beyond DEPTH bytes are dropped.
- R6: A pulse on `validate_stb` in `ST_FILL` validates the buffer when it holds at least one byte. With an empty buffer the pulse has no effect.
- R7: An IN token while the buffer is valid and not sending starts the drain. `tx_valid` rises the next cycle, and bytes appear on `tx_data` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. `tx_last` marks the final byte.
- R8: After the final byte is accepted, `buf_valid` is low, `byte_count` is 0, and new writes are accepted.
- R9: Writes while the buffer is valid are ignored, so `byte_count` is unchanged. Such writes, and any byte dropped for lack of room, set `overflow`, which only reset clears.
- R10: An IN token while no packet is ready (`ST_FILL` or `ST_SEND`) gives `nak` high for exactly the next cycle. No data moves.
- R11: A write that completes a packet in the same cycle as an IN token validates the packet, but the token is answered with NAK. The packet stays valid for the next token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous bus reset |
| mps_wr | input | 1 | Max-packet-size write strobe, preloads length |
| mps_val | input | LEN_W | Max-packet-size value |
| len_wr | input | 1 | Length register write strobe |
| len_val | input | LEN_W | Length register value |
| dp_wr | input | 1 | Data port write strobe |
| dp_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| dp_data | input | 16 | Data port write data, low byte first |
| validate_stb | input | 1 | Manual validate strobe |
| in_token | input | 1 | IN token pulse |
| tx_ready | input | 1 | Transmit side accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is offered |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Current byte is the last of the packet |
| nak | output | 1 | One-cycle NAK answer to a token |
| buf_valid | output | 1 | Packet is validated (ready or sending) |
| byte_count | output | LEN_W | Bytes held in the buffer |
| len_q | output | LEN_W | Current length register value |
| overflow | output | 1 | Sticky flag for dropped writes |

## Verification
The collision of interest is the final data write that validates a packet landing in the same cycle as an IN token. The bench drives `dp_wr` and `in_token` on the same edge against a two-byte length. It then expects the NAK pulse together with `buf_valid` high in the following cycle, and a full drain on the next token. A second collision tested is a data write arriving while a drain is running, which must leave the drained bytes intact and raise `overflow`.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_READY = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tx_ep_len_reg.sv
module tx_ep_len_reg #(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mps_wr,
    input  logic [LEN_W-1:0] mps_val,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    output logic [LEN_W-1:0] len_q
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    function automatic logic [LEN_W-1:0] clamp(input logic [LEN_W-1:0] v);
        return (v > FULL) ? FULL : v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_wr) begin
            len_q <= clamp(len_val);
        end else if (mps_wr) begin
            len_q <= clamp(mps_val);
        end
    end
endmodule

// File: rtl/tx_ep_store.sv
module tx_ep_store #(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1),
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wide,
    input  logic [15:0]      data,
    input  logic [LEN_W-1:0] len_q,
    input  logic             clr,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [LEN_W-1:0] count,
    output logic [LEN_W-1:0] next_count,
    output logic             dropped,
    output logic [7:0]       rd_data
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] room;
    logic [1:0]       take;
    logic [1:0]       want;
    logic [PTR_W-1:0] wa0;
    logic [PTR_W-1:0] wa1;

    always_comb begin
        limit = (len_q == '0) ? FULL : len_q;
        room  = (count < limit) ? (limit - count) : '0;
        want  = wide ? 2'd2 : 2'd1;
        take  = 2'd0;
        if (wr_en) begin
            if (wide) begin
                if (room >= LEN_W'(2)) begin
                    take = 2'd2;
                end else if (room != '0) begin
                    take = 2'd1;
                end
            end else if (room != '0) begin
                take = 2'd1;
            end
        end
        dropped    = wr_en && (take < want);
        next_count = count + LEN_W'(take);
        wa0        = count[PTR_W-1:0];
        wa1        = wa0 + PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= next_count;
        end
    end

    always_ff @(posedge clk) begin
        if (take != 2'd0) begin
            mem[wa0] <= data[7:0];
        end
        if (take == 2'd2) begin
            mem[wa1] <= data[15:8];
        end
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl
    import tx_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1),
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dp_wr,
    input  logic             validate_stb,
    input  logic             in_token,
    input  logic             tx_ready,
    input  logic [LEN_W-1:0] len_q,
    input  logic [LEN_W-1:0] count,
    input  logic [LEN_W-1:0] next_count,
    input  logic             dropped,
    output logic             wr_en,
    output logic             clr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             buf_valid,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             nak,
    output logic             overflow
);
    tx_state_e state_q;
    tx_state_e state_d;
    logic      accept;
    logic      at_last;
    logic      auto_hit;
    logic      manual_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        wr_en      = dp_wr && (state_q == ST_FILL);
        accept     = (state_q == ST_SEND) && tx_ready;
        at_last    = (LEN_W'(rd_ptr) == (count - LEN_W'(1)));
        clr        = accept && at_last;
        auto_hit   = (len_q != '0) && (next_count >= len_q);
        manual_hit = validate_stb && (next_count != '0);
        buf_valid  = (state_q != ST_FILL);
        tx_valid   = (state_q == ST_SEND);
        tx_last    = tx_valid && at_last;
        unique case (state_q)
            ST_FILL: begin
                if (auto_hit || manual_hit) begin
                    state_d = ST_READY;       // FILL_TO_READY
                end
            end
            ST_READY: begin
                if (in_token) begin
                    state_d = ST_SEND;        // READY_TO_SEND
                end
            end
            ST_SEND: begin
                if (clr) begin
                    state_d = ST_FILL;        // SEND_TO_FILL
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            nak      <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (clr) begin
                rd_ptr <= '0;
            end else if (accept) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            nak <= in_token && (state_q != ST_READY);
            if (dp_wr && ((state_q != ST_FILL) || dropped)) begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_ep_buffer.sv
module tx_ep_buffer #(
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mps_wr,
    input  logic [LEN_W-1:0] mps_val,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             dp_wr,
    input  logic             dp_wide,
    input  logic [15:0]      dp_data,
    input  logic             validate_stb,
    input  logic             in_token,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             nak,
    output logic             buf_valid,
    output logic [LEN_W-1:0] byte_count,
    output logic [LEN_W-1:0] len_q,
    output logic             overflow
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             wr_en;
    logic             clr;
    logic             dropped;
    logic [PTR_W-1:0] rd_ptr;
    logic [LEN_W-1:0] next_count;

    tx_ep_len_reg #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .mps_wr  (mps_wr),
        .mps_val (mps_val),
        .len_wr  (len_wr),
        .len_val (len_val),
        .len_q   (len_q)
    );

    tx_ep_store #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wide       (dp_wide),
        .data       (dp_data),
        .len_q      (len_q),
        .clr        (clr),
        .rd_ptr     (rd_ptr),
        .count      (byte_count),
        .next_count (next_count),
        .dropped    (dropped),
        .rd_data    (tx_data)
    );

    tx_ep_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dp_wr        (dp_wr),
        .validate_stb (validate_stb),
        .in_token     (in_token),
        .tx_ready     (tx_ready),
        .len_q        (len_q),
        .count        (byte_count),
        .next_count   (next_count),
        .dropped      (dropped),
        .wr_en        (wr_en),
        .clr          (clr),
        .rd_ptr       (rd_ptr),
        .buf_valid    (buf_valid),
        .tx_valid     (tx_valid),
        .tx_last      (tx_last),
        .nak          (nak),
        .overflow     (overflow)
    );
endmodule

// File: rtl/tx_ep_buffer_chk.sv
module tx_ep_buffer_chk #(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dp_wr,
    input logic             dp_wide,
    input logic             in_token,
    input logic             tx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             nak,
    input logic             buf_valid,
    input logic [LEN_W-1:0] byte_count,
    input logic [LEN_W-1:0] len_q,
    input logic             overflow
);
    a_r10_nak_when_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && !(buf_valid && !tx_valid)) |=> nak);

    a_r10_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && !buf_valid && !dp_wr) |=> (!tx_valid && $stable(byte_count)));

    a_r7_token_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && buf_valid && !tx_valid) |=> (tx_valid && !nak));

    a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r8_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (!buf_valid && byte_count == '0));

    a_r9_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r9_ignore_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && buf_valid && !tx_valid) |=> (overflow && $stable(byte_count)));

    a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && !buf_valid && !dp_wide && byte_count < len_q)
        |=> (byte_count == $past(byte_count) + LEN_W'(1)));
endmodule

bind tx_ep_buffer tx_ep_buffer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dp_wr      (dp_wr),
    .dp_wide    (dp_wide),
    .in_token   (in_token),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .nak        (nak),
    .buf_valid  (buf_valid),
    .byte_count (byte_count),
    .len_q      (len_q),
    .overflow   (overflow)
);

// File: tb/tx_ep_buffer_test.sv
`timescale 1ns/1ps
module tx_ep_buffer_test;
    localparam int DEPTH = 64;
    localparam int LEN_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mps_wr = 1'b0;
    logic [LEN_W-1:0] mps_val = '0;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_val = '0;
    logic             dp_wr = 1'b0;
    logic             dp_wide = 1'b0;
    logic [15:0]      dp_data = '0;
    logic             validate_stb = 1'b0;
    logic             in_token = 1'b0;
    logic             tx_ready = 1'b0;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_last;
    logic             nak;
    logic             buf_valid;
    logic [LEN_W-1:0] byte_count;
    logic [LEN_W-1:0] len_q;
    logic             overflow;

    int nchk = 0;
    int nerr = 0;

    int         m_len;
    int         m_cnt;
    bit         m_valid;
    bit         m_ovf;
    logic [7:0] m_mem [DEPTH];

    always #2.5 clk = ~clk;

    tx_ep_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .mps_wr(mps_wr), .mps_val(mps_val),
        .len_wr(len_wr), .len_val(len_val), .dp_wr(dp_wr), .dp_wide(dp_wide),
        .dp_data(dp_data), .validate_stb(validate_stb), .in_token(in_token),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .nak(nak), .buf_valid(buf_valid),
        .byte_count(byte_count), .len_q(len_q), .overflow(overflow)
    );

    function automatic int clamp64(int v);
        return (v > DEPTH) ? DEPTH : v;
    endfunction

    function automatic int model_limit();
        return (m_len == 0) ? DEPTH : m_len;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag);
        chk({tag, " buf_valid"}, int'(buf_valid), int'(m_valid));
        chk({tag, " byte_count"}, int'(byte_count), m_cnt);
        chk({tag, " overflow"}, int'(overflow), int'(m_ovf));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        m_len = 0; m_cnt = 0; m_valid = 0; m_ovf = 0;
    endtask

    task automatic model_write(bit wide, logic [15:0] d);
        int room;
        int take;
        int want;
        if (m_valid) begin
            m_ovf = 1;
            return;
        end
        room = (m_cnt < model_limit()) ? model_limit() - m_cnt : 0;
        want = wide ? 2 : 1;
        take = (room < want) ? room : want;
        if (take >= 1) m_mem[m_cnt] = d[7:0];
        if (take == 2) m_mem[m_cnt + 1] = d[15:8];
        if (take < want) m_ovf = 1;
        m_cnt += take;
        if (m_len != 0 && m_cnt >= m_len) m_valid = 1;
    endtask

    task automatic do_write(bit wide, logic [15:0] d);
        dp_wr = 1'b1; dp_wide = wide; dp_data = d;
        step();
        dp_wr = 1'b0; dp_wide = 1'b0;
        model_write(wide, d);
    endtask

    task automatic do_len(int v, int mps, bit both);
        len_wr = 1'b1; len_val = LEN_W'(v);
        mps_wr = both; mps_val = LEN_W'(mps);
        step();
        len_wr = 1'b0; mps_wr = 1'b0;
        m_len = clamp64(v);
        if (!m_valid && m_len != 0 && m_cnt >= m_len) m_valid = 1;
    endtask

    task automatic do_mps(int v);
        mps_wr = 1'b1; mps_val = LEN_W'(v);
        step();
        mps_wr = 1'b0;
        m_len = clamp64(v);
        if (!m_valid && m_len != 0 && m_cnt >= m_len) m_valid = 1;
    endtask

    task automatic do_validate();
        validate_stb = 1'b1;
        step();
        validate_stb = 1'b0;
        if (!m_valid && m_cnt > 0) m_valid = 1;
    endtask

    task automatic token_nak(string tag);
        in_token = 1'b1;
        step();
        in_token = 1'b0;
        chk({tag, " nak pulse"}, int'(nak), 1);
        chk({tag, " no send"}, int'(tx_valid), 0);
        chk_state(tag);
        step();
        chk({tag, " nak ends"}, int'(nak), 0);
    endtask

    task automatic drain(string tag, bit poke);
        int i;
        bit rdy;
        in_token = 1'b1;
        step();
        in_token = 1'b0;
        chk({tag, " R7 no nak"}, int'(nak), 0);
        i = 0;
        while (i < m_cnt) begin
            rdy = (($urandom % 4) != 0);
            tx_ready = rdy;
            if (poke && i == 0) begin
                dp_wr = 1'b1; dp_wide = 1'b1; dp_data = 16'hDEAD;
            end
            chk({tag, " R7 tx_valid"}, int'(tx_valid), 1);
            chk({tag, " R7 tx_data"}, int'(tx_data), int'(m_mem[i]));
            chk({tag, " R7 tx_last"}, int'(tx_last), int'(i == m_cnt - 1));
            step();
            if (dp_wr) begin
                dp_wr = 1'b0;
                m_ovf = 1;
                chk({tag, " R9 write during send"}, int'(overflow), 1);
            end
            if (rdy) i++;
        end
        tx_ready = 1'b0;
        m_valid = 0;
        m_cnt = 0;
        chk({tag, " R8 idle"}, int'(tx_valid), 0);
        chk_state({tag, " R8"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk_state("R1");
        chk("R1 len_q", int'(len_q), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 nak", int'(nak), 0);

        // R10 token on empty buffer
        token_nak("R10 empty");

        // R2 length loading and clamping
        do_mps(100);
        chk("R2 mps clamp", int'(len_q), 64);
        do_len(5, 40, 1'b1);
        chk("R2 len_wr wins", int'(len_q), 5);

        // R3 / R4 mixed widths reach length 5
        do_write(1'b0, 16'h0011);
        chk("R3 byte step", int'(byte_count), 1);
        do_write(1'b1, 16'h3322);
        chk("R3 word step", int'(byte_count), 3);
        chk("R4 not yet valid", int'(buf_valid), 0);
        do_write(1'b1, 16'h5544);
        chk_state("R4 auto validate");

        // R9 write into held buffer
        do_write(1'b0, 16'h00AA);
        chk_state("R9 ignored");
        drain("R7 first", 1'b0);

        // R9 overflow cleared only by reset
        do_reset();
        chk_state("R9 reset clears");
        chk("R1 len after reset", int'(len_q), 0);

        // R5 length zero: no auto validation
        do_write(1'b1, 16'h0201);
        do_write(1'b0, 16'h0003);
        chk_state("R5 no auto");
        // R6 manual validate
        do_validate();
        chk_state("R6 manual");
        drain("R6 drain", 1'b1);

        // R6 strobe on empty buffer has no effect
        do_validate();
        chk_state("R6 empty strobe");
        token_nak("R6 empty token");

        // R4 upper byte dropped when one byte of room
        do_reset();
        do_len(3, 0, 1'b0);
        do_write(1'b1, 16'hB2B1);
        do_write(1'b1, 16'hB4B3);
        chk_state("R4 partial word");
        drain("R4 drain", 1'b0);

        // R11 completing write together with token
        do_reset();
        do_len(2, 0, 1'b0);
        dp_wr = 1'b1; dp_wide = 1'b1; dp_data = 16'hC2C1; in_token = 1'b1;
        step();
        dp_wr = 1'b0; dp_wide = 1'b0; in_token = 1'b0;
        model_write(1'b1, 16'hC2C1);
        chk("R11 nak", int'(nak), 1);
        chk("R11 not sending", int'(tx_valid), 0);
        chk_state("R11 held");
        drain("R11 drain", 1'b0);

        // R5 writes beyond DEPTH dropped with length zero
        do_reset();
        for (int k = 0; k < DEPTH / 2; k++) do_write(1'b1, 16'(k * 257 + 3));
        chk_state("R5 full no auto");
        do_write(1'b0, 16'h0077);
        chk_state("R5 drop beyond depth");
        do_validate();
        drain("R5 drain", 1'b0);

        // random packets
        do_reset();
        for (int p = 0; p < 25; p++) begin
            if (($urandom % 2) == 0) do_len(1 + int'($urandom % 64), 0, 1'b0);
            else do_mps(1 + int'($urandom % 64));
            while (!m_valid) begin
                if (m_cnt > 0 && ($urandom % 10) == 0) do_validate();
                else do_write(1'(($urandom % 2)), 16'($urandom));
            end
            chk_state("R4 random fill");
            drain("R7 random", 1'(($urandom % 5) == 0));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule